// File: doc/BRIEF.md
# Match Region Event Vector Capture

This block gathers the report outputs of the automaton elements in one output region and turns them into stored event records. Each accepted input symbol comes with its report bits. If any report bit inside the active vector width is set, the block writes one record into a local event memory. A symbol with no report bits set writes nothing. The record holds the whole report vector for that symbol and a metadata word. The metadata word carries the byte offset of that symbol from the start of the current flow.

The active vector width comes from a static divisor selection, `DIV_SEL`. It is fixed when the block is built and does not change at run time. Report bits at or above the selected width are dropped before storage. A downstream transfer engine drains the records in arrival order. It sees the oldest record on a show-ahead read port, removes it with a pop strobe, and watches the fill count. The usable depth is the smaller of an input cap and the physical memory depth. When a record arrives while the memory is at that depth, the record is discarded and a sticky overflow flag is raised. Records already stored are never overwritten.

Top module: `match_region_capture`

## Requirements
- R1: A record is written only in a cycle where `sym_valid` is 1 and at least one report bit below the active width is set. A cycle with `sym_valid` at 0, or with no such bit set, leaves `fill` unchanged, unless a pop removes a record in that cycle.
- R2: All report bits of one symbol go into a single record. `fill` rises by at most one per cycle, and the stored vector shows every in-width bit that was set.
- R3: Bits [31:0] of `rd_meta` hold the byte offset of the record's symbol, and bits [63:32] are zero. The byte offset is the number of symbols accepted since the last `flow_start` pulse. A symbol accepted in the same cycle as `flow_start` has offset 0. A symbol presented with `sym_valid` at 0 is not counted.
- R4: The active width depends on `DIV_SEL`. Values 0, 1, 2, 3, 4 and 5 give EV_BITS, 3/4, 1/2, 1/4, 1/8 and 1/16 of EV_BITS. Report bits at or above the active width are ignored and read back as zero on `rd_vec`. A symbol whose only set bits lie at or above the active width writes no record.
- R5: Records are read out in arrival order. `rd_vec` and `rd_meta` show the oldest stored record while `fill` is nonzero. `rd_pop` removes that record at the next clock edge.
- R6: The usable depth is min(`depth_cap`, DEPTH). A record that arrives while `fill` is at the usable depth is discarded and sets `overflow`. The stored records and their order stay unchanged.
- R7: After reset, `fill` and `overflow` are 0. Once set, `overflow` stays set until a `flow_start` pulse clears it.
- R8: A pop while `fill` is 0 has no effect. A write and a pop in the same cycle leave `fill` unchanged, and the new record is queued behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_start | input | 1 | Pulse that restarts the byte offset count and clears `overflow` |
| sym_valid | input | 1 | An input symbol is accepted in this cycle |
| report_bits | input | EV_BITS | Report outputs of the region's elements for this symbol |
| depth_cap | input | $clog2(DEPTH)+1 | Usable record depth limit, static during a flow |
| rd_pop | input | 1 | Remove the oldest record |
| rd_vec | output | EV_BITS | Event vector of the oldest record, zero above the active width |
| rd_meta | output | 64 | Metadata of the oldest record, byte offset in bits [31:0] |
| fill | output | $clog2(DEPTH)+1 | Number of stored records |
| overflow | output | 1 | Sticky flag: a record was discarded because the memory was full |

## Verification
A wrong write decision shows on `fill` one cycle after the offending symbol. A wrong offset counter or wrong width masking shows on `rd_meta` or `rd_vec` in the same cycle, because the head record is visible combinationally. The bench sweeps a single report bit across every position of a 64-bit bank with a 3/4 divisor. For each symbol it predicts whether a record should appear, what vector it holds and what offset it carries. It then fills the memory past a small cap and past the physical depth, and checks that the surviving records keep their order and offsets and that `overflow` behaves as stated.

// File: rtl/match_region_capture.sv
module match_region_capture #(
  parameter int EV_BITS   = 1024,
  parameter int DEPTH     = 1024,
  parameter int DIV_SEL   = 0,
  parameter int META_BITS = 64,
  parameter int OFF_BITS  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flow_start,
  input  logic                       sym_valid,
  input  logic [EV_BITS-1:0]         report_bits,
  input  logic [$clog2(DEPTH):0]     depth_cap,
  input  logic                       rd_pop,
  output logic [EV_BITS-1:0]         rd_vec,
  output logic [META_BITS-1:0]       rd_meta,
  output logic [$clog2(DEPTH):0]     fill,
  output logic                       overflow
);
  localparam int VW = (DIV_SEL == 0) ? EV_BITS :
                      (DIV_SEL == 1) ? (EV_BITS * 3) / 4 :
                      (EV_BITS >> (DIV_SEL - 1));
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int RW = VW + OFF_BITS;

  logic [OFF_BITS-1:0] offset_q;
  logic [OFF_BITS-1:0] sym_off;
  logic [VW-1:0]       narrow;
  logic [AW-1:0]       wr_ptr, rd_ptr;
  logic [CW-1:0]       cap_eff;
  logic                hit, full, do_wr, do_rd;
  logic [RW-1:0]       mem [DEPTH];
  logic [RW-1:0]       head;

  assign narrow  = report_bits[VW-1:0];
  assign sym_off = flow_start ? '0 : offset_q;
  assign cap_eff = (depth_cap > CW'(DEPTH)) ? CW'(DEPTH) : depth_cap;
  assign hit     = sym_valid && (|narrow);
  assign full    = fill >= cap_eff;
  assign do_wr   = hit && !full;
  assign do_rd   = rd_pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      offset_q <= '0;
    else if (flow_start)
      offset_q <= sym_valid ? OFF_BITS'(1) : '0;
    else if (sym_valid)
      offset_q <= offset_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr)
      mem[wr_ptr] <= {sym_off, narrow};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      fill     <= fill + CW'(do_wr) - CW'(do_rd);
      overflow <= (overflow && !flow_start) || (hit && full);
    end
  end

  assign head    = mem[rd_ptr];
  assign rd_meta = {{(META_BITS-OFF_BITS){1'b0}}, head[RW-1:VW]};

  generate
    if (VW < EV_BITS) begin : g_pad
      assign rd_vec = {{(EV_BITS-VW){1'b0}}, head[VW-1:0]};
    end else begin : g_full
      assign rd_vec = head[VW-1:0];
    end
  endgenerate

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_drop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && full && !rd_pop) |=> $stable(fill));

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && full) |=> overflow);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flow_start) |=> overflow);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !rd_pop) |=> $stable(fill));

  p_one_rec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0 && !sym_valid) |=> (fill <= $past(fill)));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !sym_valid) |=> (fill == '0));
endmodule

// File: tb/sim_match_region_capture.sv
module sim_match_region_capture;
  localparam int EVB = 64;
  localparam int DEP = 16;
  localparam int VW  = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flow_start = 1'b0;
  logic sym_valid = 1'b0;
  logic [EVB-1:0] report_bits = '0;
  logic [4:0] depth_cap = 5'd16;
  logic rd_pop = 1'b0;
  logic [EVB-1:0] rd_vec;
  logic [63:0] rd_meta;
  logic [4:0] fill;
  logic overflow;

  int checks = 0;
  int errors = 0;
  int off = 0;
  bit done = 0;

  match_region_capture #(.EV_BITS(EVB), .DEPTH(DEP), .DIV_SEL(1)) u0 (
    .clk(clk), .rst_n(rst_n), .flow_start(flow_start), .sym_valid(sym_valid),
    .report_bits(report_bits), .depth_cap(depth_cap), .rd_pop(rd_pop),
    .rd_vec(rd_vec), .rd_meta(rd_meta), .fill(fill), .overflow(overflow));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [EVB-1:0] b);
    sym_valid = 1'b1; report_bits = b;
    tick;
    sym_valid = 1'b0; report_bits = '0;
    off++;
  endtask

  task automatic pop;
    rd_pop = 1'b1;
    tick;
    rd_pop = 1'b0;
  endtask

  task automatic start_flow;
    flow_start = 1'b1;
    tick;
    flow_start = 1'b0;
    off = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick; tick;
    rst_n = 1'b1;
    tick;
    chk("R7 reset fill", 64'(fill), 0);
    chk("R7 reset overflow", 64'(overflow), 0);

    // R4 / R1 / R3 / R5: single-bit sweep across the whole bank
    start_flow;
    for (int b = 0; b < EVB; b++) begin
      int o;
      o = off;
      send(64'd1 << b);
      if (b < VW) begin
        chk("R1 record written", 64'(fill), 1);
        chk("R4 vector bit", rd_vec, 64'd1 << b);
        chk("R3 offset", rd_meta, 64'(o));
        pop;
        chk("R5 pop empties", 64'(fill), 0);
      end else begin
        chk("R4 high bit ignored", 64'(fill), 0);
      end
    end

    // R2: many bits in one symbol, one record, high bits cleared
    send('1);
    chk("R2 single record", 64'(fill), 1);
    chk("R2 all in-width bits", rd_vec, (64'd1 << VW) - 1);
    chk("R3 offset after sweep", rd_meta, 64'(off - 1));
    pop;

    // R1 / R3: invalid symbol is neither stored nor counted
    report_bits = 64'hF; tick; report_bits = '0;
    chk("R1 invalid symbol no record", 64'(fill), 0);
    send(64'h2);
    chk("R3 invalid symbol not counted", rd_meta, 64'(off - 1));
    pop;

    // R3: symbol accepted with flow_start has offset 0
    flow_start = 1'b1; sym_valid = 1'b1; report_bits = 64'h10;
    tick;
    flow_start = 1'b0; sym_valid = 1'b0; report_bits = '0; off = 1;
    chk("R3 start-cycle offset", rd_meta, 0);
    send(64'h20);
    pop;
    chk("R3 next offset", rd_meta, 1);
    pop;

    // R6 / R5 / R7: cap of 5, seven arrivals
    depth_cap = 5'd5;
    start_flow;
    for (int i = 0; i < 7; i++) send(64'd1 << i);
    chk("R6 fill at cap", 64'(fill), 5);
    chk("R6 overflow set", 64'(overflow), 1);
    for (int i = 0; i < 5; i++) begin
      chk("R5 order vector", rd_vec, 64'd1 << i);
      chk("R5 order offset", rd_meta, 64'(i));
      pop;
    end
    chk("R6 drained", 64'(fill), 0);
    chk("R7 overflow sticky", 64'(overflow), 1);
    start_flow;
    chk("R7 flow_start clears overflow", 64'(overflow), 0);

    // R8: pop on empty, then write and pop together
    pop;
    chk("R8 empty pop", 64'(fill), 0);
    send(64'h8);
    sym_valid = 1'b1; report_bits = 64'h80; rd_pop = 1'b1;
    tick;
    sym_valid = 1'b0; report_bits = '0; rd_pop = 1'b0; off++;
    chk("R8 write+pop fill", 64'(fill), 1);
    chk("R8 write+pop head", rd_vec, 64'h80);
    chk("R8 write+pop offset", rd_meta, 1);
    pop;

    // R6: cap above physical depth clamps to DEPTH
    depth_cap = 5'd31;
    start_flow;
    for (int i = 0; i < DEP + 1; i++) send(64'd1 << i);
    chk("R6 clamp fill", 64'(fill), DEP);
    chk("R6 clamp overflow", 64'(overflow), 1);
    for (int i = 0; i < DEP; i++) begin
      chk("R6 stored kept", rd_meta, 64'(i));
      pop;
    end
    chk("R6 clamp drained", 64'(fill), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule